// File: doc/BRIEF.md
# Split Accumulator Pipeline with Aligned Observer

This block folds a stream of input words into two running accumulators over two pipeline stages. Stage one adds each accepted input to accumulator A. It hands the sum to stage two through a one-entry hand-off queue. Stage two rotates that sum left by three bits, XORs it with accumulator B, stores the result in B and emits it as a result word. The result sequence equals that of a single-step model in which both accumulators update together for each input. The split only delays each result by one cycle, and a shorter combinational path is gained in exchange.

A second output reports, for each input, the difference A minus B taken from the accumulator values held just before that input was applied. Each stage pushes the old value of its own accumulator into a small snapshot queue. The observer emits only when both snapshot queues hold an entry, and it pops both together. An observation therefore never combines accumulator values from different inputs, even though the two stages run out of step. All three ports use valid/ready handshakes, and both outputs come from registers.

Top module: `split_accum_pipe`

## Requirements
- R1: While reset is held, and in the first cycle after it, `res_valid` and `obs_valid` are low and `in_ready` is high. Both accumulators start at zero.
- R2: The k-th result word equals B_k, where A_k = x_k + A_(k-1) and B_k = rotl3(A_k) XOR B_(k-1). All arithmetic is modulo 2^W, and rotl3 is a left rotation by 3 bits.
- R3: The k-th observation word equals A_(k-1) - B_(k-1) modulo 2^W, which is the difference of the accumulator values before input k.
- R4: An input accepted at clock edge e sets `res_valid` after edge e+1 and `obs_valid` after edge e+2, provided both outputs are empty and ready.
- R5: While both outputs stay ready, `in_ready` stays high, and a burst of N inputs is accepted in N consecutive cycles.
- R6: While an output is valid and its ready is low, that output stays valid and its data stays unchanged.
- R7: With the observation output stalled and the result output ready, at most four inputs are accepted. No observation or result is lost or reordered once the stall ends.
- R8: With the result output stalled and the observation output ready, at most four inputs are accepted. No result is lost or reordered once the stall ends. No internal queue is pushed while full or popped while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_data | input | W | Input word |
| res_valid | output | 1 | Result word present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | W | New value of accumulator B |
| obs_valid | output | 1 | Observation word present |
| obs_ready | input | 1 | Consumer takes the observation this cycle |
| obs_data | output | W | Old A minus old B for one input |

## Verification
The assertions assume that the environment obeys the handshake. The block only promises stable output data while it holds valid high against a low ready, and the bench is the party that must respect this on the input side. The bench therefore keeps `in_data` fixed and `in_valid` high until `in_ready` accepts the word. It changes inputs and readies only on falling edges, so every transfer is decided by stable levels. The ready patterns cover always ready, random, and each output held stalled for many cycles. These cover the queue-full and same-cycle pop-and-push cases on which the overflow and underflow assertions depend.

// File: rtl/spo_pkg.sv
package spo_pkg;
  localparam int unsigned ROT_BITS = 3;
  localparam int unsigned DEF_WIDTH = 16;
endpackage

// File: rtl/spo_fifo.sv
module spo_fifo #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        if (wr_ptr == AW'(DEPTH - 1)) wr_ptr <= '0;
        else                          wr_ptr <= wr_ptr + AW'(1);
      end
      if (pop) begin
        if (rd_ptr == AW'(DEPTH - 1)) rd_ptr <= '0;
        else                          rd_ptr <= rd_ptr + AW'(1);
      end
      if (push && !pop)      count <= count + CW'(1);
      else if (pop && !push) count <= count - CW'(1);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/spo_out_reg.sv
module spo_out_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         space
);
  assign space = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
endmodule

// File: rtl/split_accum_pipe.sv
module split_accum_pipe #(
  parameter int unsigned W          = spo_pkg::DEF_WIDTH,
  parameter int unsigned SNAP_DEPTH = 2,
  parameter int unsigned LINK_DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data,
  output logic         obs_valid,
  input  logic         obs_ready,
  output logic [W-1:0] obs_data
);
  localparam int unsigned ROT = spo_pkg::ROT_BITS;

  function automatic logic [W-1:0] step_a(input logic [W-1:0] x, input logic [W-1:0] a);
    return x + a;
  endfunction

  function automatic logic [W-1:0] step_b(input logic [W-1:0] y, input logic [W-1:0] b);
    return {y[W-1-ROT:0], y[W-1:W-ROT]} ^ b;
  endfunction

  function automatic logic [W-1:0] view(input logic [W-1:0] a, input logic [W-1:0] b);
    return a - b;
  endfunction

  logic [W-1:0] acc_a, acc_b;
  logic [W-1:0] link_dout, snap_a_dout, snap_b_dout;
  logic         link_empty, link_full;
  logic         snap_a_empty, snap_a_full, snap_b_empty, snap_b_full;
  logic         res_space, obs_space;
  logic         link_space, snap_a_space, snap_b_space;
  logic         s1_fire, s2_fire, obs_fire;
  logic [W-1:0] y_new, z_new;

  assign y_new = step_a(in_data, acc_a);
  assign z_new = step_b(link_dout, acc_b);

  // Observer pops both snapshot heads together
  assign obs_fire     = obs_space && !snap_a_empty && !snap_b_empty;
  assign snap_a_space = !snap_a_full || obs_fire;
  assign snap_b_space = !snap_b_full || obs_fire;

  // Stage two takes the link head before stage one refills it
  assign s2_fire    = !link_empty && res_space && snap_b_space;
  assign link_space = !link_full || s2_fire;

  assign in_ready = link_space && snap_a_space;
  assign s1_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0;
      acc_b <= '0;
    end else begin
      if (s1_fire) acc_a <= y_new;
      if (s2_fire) acc_b <= z_new;
    end
  end

  spo_fifo #(.W(W), .DEPTH(LINK_DEPTH)) u_link (
    .clk(clk), .rst(rst),
    .push(s1_fire), .din(y_new),
    .pop(s2_fire), .dout(link_dout),
    .empty(link_empty), .full(link_full)
  );

  spo_fifo #(.W(W), .DEPTH(SNAP_DEPTH)) u_snap_a (
    .clk(clk), .rst(rst),
    .push(s1_fire), .din(acc_a),
    .pop(obs_fire), .dout(snap_a_dout),
    .empty(snap_a_empty), .full(snap_a_full)
  );

  spo_fifo #(.W(W), .DEPTH(SNAP_DEPTH)) u_snap_b (
    .clk(clk), .rst(rst),
    .push(s2_fire), .din(acc_b),
    .pop(obs_fire), .dout(snap_b_dout),
    .empty(snap_b_empty), .full(snap_b_full)
  );

  spo_out_reg #(.W(W)) u_res (
    .clk(clk), .rst(rst),
    .load(s2_fire), .din(z_new),
    .ready(res_ready), .valid(res_valid),
    .data(res_data), .space(res_space)
  );

  spo_out_reg #(.W(W)) u_obs (
    .clk(clk), .rst(rst),
    .load(obs_fire), .din(view(snap_a_dout, snap_b_dout)),
    .ready(obs_ready), .valid(obs_valid),
    .data(obs_data), .space(obs_space)
  );

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && !obs_valid && in_ready));
  assert_result_follows_input_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !$past(res_valid)) |-> !link_full || $past(!link_empty));
endmodule

// File: tb/tb_split_accum_pipe.sv
module tb_split_accum_pipe;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         res_valid, obs_valid;
  logic         res_ready = 1'b0, obs_ready = 1'b0;
  logic [W-1:0] res_data, obs_data;

  int checks = 0, errors = 0;
  int res_mode = 0, obs_mode = 0;   // 0 ready, 1 random, 2 stalled
  int cyc = 0;
  logic [W-1:0] m_a = '0, m_b = '0;
  logic [W-1:0] exp_res[$], exp_obs[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  split_accum_pipe #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .obs_valid(obs_valid), .obs_ready(obs_ready), .obs_data(obs_data)
  );

  function automatic logic [W-1:0] rotl3(input logic [W-1:0] v);
    return (v << 3) | (v >> (W - 3));
  endfunction

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_accept(input logic [W-1:0] x);
    logic [W-1:0] na, nb;
    exp_obs.push_back(m_a - m_b);
    na = x + m_a;
    nb = rotl3(na) ^ m_b;
    exp_res.push_back(nb);
    m_a = na;
    m_b = nb;
  endtask

  function automatic bit pick(input int mode);
    if (mode == 0) return 1'b1;
    if (mode == 2) return 1'b0;
    return 1'($urandom_range(0, 1));
  endfunction

  // Monitor: scoreboard comparison of both outputs (R2, R3)
  initial begin
    forever begin
      @(negedge clk);
      res_ready = pick(res_mode);
      obs_ready = pick(obs_mode);
      #1;
      if (!rst && res_valid && res_ready) begin
        if (exp_res.size() == 0) check(1'b0, "R2 unexpected result", res_data, '0);
        else begin
          logic [W-1:0] e;
          e = exp_res.pop_front();
          check(res_data == e, "R2 result word", res_data, e);
        end
      end
      if (!rst && obs_valid && obs_ready) begin
        if (exp_obs.size() == 0) check(1'b0, "R3 unexpected observation", obs_data, '0);
        else begin
          logic [W-1:0] e;
          e = exp_obs.pop_front();
          check(obs_data == e, "R3 observation word", obs_data, e);
        end
      end
    end
  end

  // Driver: called on a falling edge, returns on a later falling edge
  task automatic send(input logic [W-1:0] x);
    bit done;
    done = 1'b0;
    in_valid = 1'b1;
    in_data  = x;
    while (!done) begin
      #2;
      if (in_ready) begin
        done = 1'b1;
        model_accept(x);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic offer(input int n, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      logic [W-1:0] x;
      x = W'($urandom);
      in_valid = 1'b1;
      in_data  = x;
      #2;
      if (in_ready) begin
        acc++;
        model_accept(x);
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain;
    res_mode = 0;
    obs_mode = 0;
    for (int i = 0; i < 200 && (exp_res.size() != 0 || exp_obs.size() != 0); i++)
      @(negedge clk);
    check(exp_res.size() == 0 && exp_obs.size() == 0, "R7 drain complete",
          W'(exp_res.size()), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc, start;
    repeat (3) @(negedge clk);
    #2;
    check(!res_valid && !obs_valid && in_ready, "R1 state during reset",
          {res_valid, obs_valid, in_ready}, 3'b001);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #2;
    check(!res_valid && !obs_valid && in_ready, "R1 state after reset",
          {res_valid, obs_valid, in_ready}, 3'b001);

    // R4 latency of a single input with zero accumulators
    send(16'h0001);
    #1;
    check(!res_valid, "R4 result not yet valid", res_valid, 1'b0);
    @(negedge clk);
    #1;
    check(res_valid && res_data == 16'h0008, "R4 result after second edge", res_data, 16'h0008);
    check(!obs_valid, "R4 observation not yet valid", obs_valid, 1'b0);
    @(negedge clk);
    #1;
    check(obs_valid && obs_data == 16'h0000, "R4 observation after third edge", obs_data, 16'h0000);
    drain();

    // R5 burst throughput
    start = cyc;
    for (int i = 0; i < 16; i++) send(W'(16'h1111 * i + 3));
    check((cyc - start) == 16, "R5 burst of 16 in 16 cycles", W'(cyc - start), 16);
    drain();

    // R6 result held while stalled
    res_mode = 2;
    send(16'hBEEF);
    repeat (3) @(negedge clk);
    #1;
    begin
      logic [W-1:0] held;
      held = res_data;
      repeat (4) @(negedge clk);
      #1;
      check(res_valid && res_data == held, "R6 result held under stall", res_data, held);
    end
    drain();

    // R7 observation stall
    obs_mode = 2;
    offer(20, acc);
    check(acc >= 1 && acc <= 4, "R7 accepted under observation stall", W'(acc), 4);
    drain();

    // R8 result stall
    res_mode = 2;
    offer(20, acc);
    check(acc >= 1 && acc <= 4, "R8 accepted under result stall", W'(acc), 4);
    drain();

    // R2/R3 random traffic with random backpressure
    res_mode = 1;
    obs_mode = 1;
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      else send(W'($urandom));
    end
    drain();

    // corner data: all ones and alternating patterns
    send(16'hFFFF);
    send(16'hFFFF);
    send(16'hAAAA);
    send(16'h5555);
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule